// File: doc/BRIEF.md
# JESD204B Lane Receive Synchronizer

This block sits behind the 8b/10b decoder of one receive lane of a subclass-0 JESD204B link. Each clock it takes one decoded octet with its control-character flag and the decoder's disparity and not-in-table error flags. It drives the active-low SYNC request and moves the lane through three phases in order: code group synchronization, the initial lane alignment sequence (ILAS) and the data phase. It also drives an enable that the transceiver uses to permit comma realignment. That enable is held high until ILAS has finished and is low for the whole data phase. This keeps in-band control characters in the data stream from shifting the byte boundary.

In the data phase, the transmitter may send a control character in place of a frame's final octet when that octet repeats the previous frame's final octet. The block puts the original value back. It emits frame-aligned octets with a valid strobe, a start-of-frame marker and a start-of-multiframe marker. Misplaced or unknown control characters and table errors are counted. When the count reaches a threshold, the block asserts SYNC again. The only way to recover is a complete new code group synchronization.

Top module: `jesd_lane_sync`

## Requirements
- R1: While reset is held and right after it, `sync_n` is 0, `comma_align_en` is 1, `link_up` is 0 and `out_valid` is 0.
- R2: `sync_n` goes high on the clock edge that samples the fourth consecutive K28.5 (octet 0xBC with `rx_is_k`=1) carrying no disparity or not-in-table error. Any other octet, or any error flag, restarts the count at zero.
- R3: Once `sync_n` is high, further K28.5 octets are skipped. The first octet that is not K28.5 starts ILAS. `comma_align_en` stays 1 throughout ILAS.
- R4: ILAS spans 4 multiframes, and each one ends with K28.3 (0x7C, `rx_is_k`=1). On the edge that samples the fourth K28.3, `link_up` rises and `comma_align_en` falls. The next octet is the first data octet and lies at frame position 0.
- R5: In the data phase, every input octet appears on `out_data` with `out_valid`=1 one clock later. `out_sof` marks frame position 0, with F=2 octets per frame. `out_somf` marks frame position 0 of frame 0 of each K=16-frame multiframe.
- R6: A K28.7 (0xFC, `rx_is_k`=1) at the last position of a frame is output as the previous frame's last output octet.
- R7: A K28.3 at the last position of a frame in the data phase is restored in the same way as R6 and is not counted as an error.
- R8: During the data phase, no control character can raise `comma_align_en`, whatever its value or position.
- R9: In the data phase, these each count one error: a control character other than K28.7 or K28.3, a K28.7 or K28.3 at a position other than the last, and a not-in-table flag. A disparity flag alone does not count. An erroneous octet is still output unchanged. The error that brings the count up to `err_thresh` drops `link_up`, raises `comma_align_en` and drives `sync_n` low on the same edge.
- R10: After SYNC has been reasserted, the lane returns to the data phase only through a new R2 synchronization and a complete ILAS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_octet | input | 8 | Decoded octet |
| rx_is_k | input | 1 | Octet is a control character |
| rx_disp_err | input | 1 | Running-disparity error from the decoder |
| rx_nit_err | input | 1 | Code-group-not-in-table error from the decoder |
| err_thresh | input | ERR_W | Number of data-phase errors that forces resynchronization |
| sync_n | output | 1 | Active-low synchronization request to the transmitter |
| comma_align_en | output | 1 | Permits comma realignment in the transceiver |
| link_up | output | 1 | Lane is in the data phase |
| out_data | output | 8 | Restored data octet |
| out_valid | output | 1 | `out_data` holds a data-phase octet |
| out_sof | output | 1 | Octet is the first of a frame |
| out_somf | output | 1 | Octet is the first of a multiframe |

## Verification
If the frame position counter is wrong, restoration lands on the wrong octet. This shows on `out_data` within one frame of the first repeated frame end, and `out_sof` drifts from the first data octet onward. A wrong synchronization or ILAS counter moves the edge on which `sync_n` rises or `link_up` rises, and the per-cycle comparison catches this on that exact edge. An error counter that is off by one moves the edge on which `sync_n` falls during the error burst.

// File: rtl/jesd_lane_sync.sv
module jesd_lane_sync #(
  parameter int F_OCT    = 2,
  parameter int K_FRM    = 16,
  parameter int CGS_NEED = 4,
  parameter int ILAS_MF  = 4,
  parameter int ERR_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_octet,
  input  logic             rx_is_k,
  input  logic             rx_disp_err,
  input  logic             rx_nit_err,
  input  logic [ERR_W-1:0] err_thresh,
  output logic             sync_n,
  output logic             comma_align_en,
  output logic             link_up,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_somf
);
  localparam int FP_W = (F_OCT > 1) ? $clog2(F_OCT) : 1;
  localparam int MF_W = (K_FRM > 1) ? $clog2(K_FRM) : 1;
  localparam int CG_W = $clog2(CGS_NEED + 1);
  localparam int IM_W = $clog2(ILAS_MF + 1);

  typedef enum logic [1:0] {S_CGS, S_WAIT, S_ILAS, S_DATA} st_t;

  st_t              state;
  logic             sync_q;
  logic [CG_W-1:0]  cgs_cnt;
  logic [IM_W-1:0]  mf_seen;
  logic [FP_W-1:0]  fpos;
  logic [MF_W-1:0]  mfpos;
  logic [ERR_W-1:0] err_cnt;
  logic [7:0]       last_q;

  wire             is_comma   = rx_is_k && (rx_octet == 8'hBC);
  wire             is_lane_end = rx_is_k && (rx_octet == 8'h7C);
  wire             is_frm_rep = rx_is_k && (rx_octet == 8'hFC);
  wire             at_last    = (fpos == FP_W'(F_OCT - 1));
  wire             marker_ok  = (is_lane_end || is_frm_rep) && at_last;
  wire             bad        = (state == S_DATA) && (rx_nit_err || (rx_is_k && !marker_ok));
  wire [ERR_W:0]   err_next   = {1'b0, err_cnt} + 1'b1;
  wire             trip       = bad && (err_next >= {1'b0, err_thresh});
  wire [7:0]       data_fix   = marker_ok ? last_q : rx_octet;

  assign sync_n         = sync_q;
  assign link_up        = (state == S_DATA);
  assign comma_align_en = (state != S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_CGS;
      sync_q    <= 1'b0;
      cgs_cnt   <= '0;
      mf_seen   <= '0;
      fpos      <= '0;
      mfpos     <= '0;
      err_cnt   <= '0;
      last_q    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_somf  <= 1'b0;
    end else begin
      out_valid <= (state == S_DATA);
      out_sof   <= (state == S_DATA) && (fpos == '0);
      out_somf  <= (state == S_DATA) && (fpos == '0) && (mfpos == '0);
      out_data  <= data_fix;
      case (state)
        S_CGS: begin
          if (is_comma && !rx_disp_err && !rx_nit_err) begin
            if (cgs_cnt == CG_W'(CGS_NEED - 1)) begin
              state   <= S_WAIT;
              sync_q  <= 1'b1;
              cgs_cnt <= '0;
            end else begin
              cgs_cnt <= cgs_cnt + 1'b1;
            end
          end else begin
            cgs_cnt <= '0;
          end
        end
        S_WAIT: begin
          if (!is_comma) begin
            state   <= S_ILAS;
            mf_seen <= '0;
          end
        end
        S_ILAS: begin
          if (is_lane_end) begin
            if (mf_seen == IM_W'(ILAS_MF - 1)) begin
              state   <= S_DATA;
              fpos    <= '0;
              mfpos   <= '0;
              err_cnt <= '0;
            end else begin
              mf_seen <= mf_seen + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (at_last) begin
            fpos   <= '0;
            last_q <= data_fix;
            mfpos  <= (mfpos == MF_W'(K_FRM - 1)) ? '0 : mfpos + 1'b1;
          end else begin
            fpos <= fpos + 1'b1;
          end
          if (bad) begin
            if (trip) begin
              state   <= S_CGS;
              sync_q  <= 1'b0;
              cgs_cnt <= '0;
            end else begin
              err_cnt <= err_next[ERR_W-1:0];
            end
          end
        end
        default: state <= S_CGS;
      endcase
    end
  end

  a_r2_release_on_clean_comma: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> $past(is_comma && !rx_disp_err && !rx_nit_err));

  a_r4_data_after_lane_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(is_lane_end));

  a_r8_no_realign_with_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sync_n) |-> !comma_align_en);

  a_r5_sof_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ((F_OCT > 1) && out_sof) |=> !out_sof);

  a_r9_drop_only_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> $past(link_up));
endmodule

// File: tb/jesd_lane_sync_bench.sv
module jesd_lane_sync_bench;
  localparam int F = 2;
  localparam int K = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_octet = '0;
  logic       rx_is_k = 1'b0, rx_disp_err = 1'b0, rx_nit_err = 1'b0;
  logic [3:0] err_thresh = 4'd3;
  logic       sync_n, comma_align_en, link_up, out_valid, out_sof, out_somf;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  jesd_lane_sync u_jesd_lane_sync (
    .clk(clk), .rst_n(rst_n), .rx_octet(rx_octet), .rx_is_k(rx_is_k),
    .rx_disp_err(rx_disp_err), .rx_nit_err(rx_nit_err), .err_thresh(err_thresh),
    .sync_n(sync_n), .comma_align_en(comma_align_en), .link_up(link_up),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_somf(out_somf));

  int total = 0, fails = 0;
  int m_state = 0, m_cgs = 0, m_k3 = 0, m_fpos = 0, m_mf = 0, m_errs = 0;
  bit e_sync = 0, e_link = 0, e_valid = 0, e_sof = 0, e_somf = 0;
  int e_data = 0;
  bit have_prev = 0;
  int prev_last = 0;
  bit use_k3 = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input int oct, input bit k, input bit nit, input bit disp, input int orig);
    bit bad;
    rx_octet = oct[7:0]; rx_is_k = k; rx_nit_err = nit; rx_disp_err = disp;
    @(posedge clk);
    e_valid = (m_state == 3);
    if (m_state == 3) begin
      e_data = orig; e_sof = (m_fpos == 0); e_somf = (m_fpos == 0) && (m_mf == 0);
    end
    case (m_state)
      0: begin
        if (k && oct == 'hBC && !nit && !disp) begin
          m_cgs++;
          if (m_cgs == 4) begin m_state = 1; e_sync = 1; m_cgs = 0; end
        end else m_cgs = 0;
      end
      1: if (!(k && oct == 'hBC)) begin m_state = 2; m_k3 = 0; end
      2: if (k && oct == 'h7C) begin
        m_k3++;
        if (m_k3 == 4) begin
          m_state = 3; m_fpos = 0; m_mf = 0; m_errs = 0; e_link = 1;
        end
      end
      default: begin
        bad = nit || (k && !((oct == 'hFC || oct == 'h7C) && m_fpos == F - 1));
        m_fpos++;
        if (m_fpos == F) begin m_fpos = 0; m_mf = (m_mf + 1) % K; end
        if (bad) begin
          m_errs++;
          if (m_errs >= int'(err_thresh)) begin
            m_state = 0; m_cgs = 0; e_sync = 0; e_link = 0;
          end
        end
      end
    endcase
    #1;
    chk("R2 R9 R10 sync_n", sync_n, e_sync);
    chk("R3 R4 R8 comma_align_en", comma_align_en, !e_link);
    chk("R4 R9 link_up", link_up, e_link);
    chk("R5 out_valid", out_valid, e_valid);
    if (e_valid) begin
      chk("R5 R6 R7 out_data", out_data, e_data);
      chk("R5 out_sof", out_sof, e_sof);
      chk("R5 out_somf", out_somf, e_somf);
    end
  endtask

  task automatic do_ilas();
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < F * K; i++) begin
        if (i == 0) send('h1C, 1, 0, 0, 'h1C);
        else if (i == F * K - 1) send('h7C, 1, 0, 0, 'h7C);
        else send('h20 + i, 0, 0, 0, 'h20 + i);
      end
  endtask

  task automatic do_ramp(input int nfr, input int base);
    int lst;
    have_prev = 0;
    for (int j = 0; j < nfr; j++) begin
      send((base + j) & 'hFF, 0, 0, (j % 5 == 0), (base + j) & 'hFF);
      lst = ((base + j) / 3) & 'hFF;
      if (have_prev && lst == prev_last) begin
        send(use_k3 ? 'h7C : 'hFC, 1, 0, 0, lst);
        use_k3 = !use_k3;
      end else send(lst, 0, 0, 0, lst);
      prev_last = lst; have_prev = 1;
    end
  endtask

  task automatic do_cgs();
    for (int i = 0; i < 6; i++) send('hBC, 1, 0, 0, 'hBC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sync_n", sync_n, 0);
    chk("R1 comma_align_en", comma_align_en, 1);
    chk("R1 link_up", link_up, 0);
    chk("R1 out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 sync_n after release", sync_n, 0);
    // R2: interrupted count, then a clean run
    send('hBC, 1, 0, 0, 0); send('hBC, 1, 0, 0, 0);
    send('hBC, 1, 0, 1, 0);
    send('hBC, 1, 0, 0, 0); send('hBC, 1, 0, 0, 0); send('hBC, 1, 0, 0, 0);
    send('h55, 0, 0, 0, 0);
    do_cgs();
    do_ilas();
    // R5 R6 R7 ramp with repeated frame ends and ignored disparity flags (R9)
    do_ramp(80, 0);
    // R9: two errors below threshold, then the third trips
    send('hBC, 1, 0, 0, 'hBC); send('h55, 0, 0, 0, 'h55);
    send('hFC, 1, 0, 0, 'hFC); send('h56, 0, 0, 0, 'h56);
    send('h11, 0, 1, 0, 'h11);
    send('h12, 0, 0, 0, 'h12);
    // R10: data must not resume without a full new sync
    for (int i = 0; i < 8; i++) send('h7C, 1, 0, 0, 'h7C);
    do_cgs();
    do_ilas();
    do_ramp(40, 200);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule